// File: doc/BRIEF.md
# Bus Device Enumeration Search Pass

This block runs a single pass of the binary-tree identifier search used to list every device sharing a single-wire, open-drain bus. It issues a bus reset, sends the search command, and then walks the 64 identifier bit positions. For each position it reads the bit, reads its complement, and writes back the branch it follows. When the two reads disagree, every responding device agrees on that bit. When both reads are 0, devices are in conflict and the block picks a branch. When both are 1, the bus is inconsistent.

It does not time the bus slots itself. Each reset, read or write slot is requested from a separate slot engine through a one-cycle request and a one-cycle acknowledge. The acknowledge returns the sampled line level, or the presence result for a reset.

Software enumerates a bus by calling the pass repeatedly. The first call uses a starting discrepancy of 0xFF. Each later call feeds back the identifier and the next-discrepancy position from the previous pass. The search is finished when a pass returns 0.

Top module: `owsr_search_pass`

## Requirements
- R1: After reset, `bus_req` and `done` are low, `status` is 0, `next_disc` is 0 and `id_out` is 0.
- R2: A `start` pulse makes the first request a reset slot (`bus_op`=0). If the acknowledge returns `bus_rbit`=0 (no presence), the pass ends with `done` and `status`=1 (presence error), and no further slot is requested.
- R3: After a reset slot with presence, eight write slots (`bus_op`=1) carry the command byte 0xF0, least significant bit first.
- R4: Each of the 64 positions, counted down from 64 to 1, uses two read slots (`bus_op`=2), true bit then complement, followed by one write slot. A complete pass issues exactly 201 slots.
- R5: If both reads of a position return 1, the pass ends with `done` and `status`=2 (data error), and no further slot is requested.
- R6: When both reads return 0, the block writes 1 in two cases: the starting discrepancy is greater than the position, or the previous identifier bit at that position is 1 and the position differs from the starting discrepancy. In every other conflict case it writes 0. Without a conflict it writes the bit read first.
- R7: `next_disc` is the last position, in search order (the smallest number), where a conflict was resolved to 1. It is 0 when no such position occurs.
- R8: The bit written for position p is stored at `id_out` bit 64-p, so the first bit searched is the least significant bit.
- R9: `done` is a single-cycle pulse. `id_out`, `next_disc` and `status` hold their values from the end of a pass until the next `start`.
- R10: Every request is one cycle long. No new request is made until the slot engine acknowledges the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a pass; only accepted while idle |
| start_disc | input | 8 | Discrepancy position the pass starts from (0xFF for a fresh enumeration) |
| prev_id | input | 64 | Identifier returned by the previous pass |
| bus_req | output | 1 | One-cycle slot request to the slot engine |
| bus_op | output | 2 | Slot kind: 0 reset, 1 write, 2 read |
| bus_wbit | output | 1 | Bit to send in a write slot |
| bus_ack | input | 1 | One-cycle slot completion from the slot engine |
| bus_rbit | input | 1 | Sampled line level for a read, or 1 for presence after a reset |
| id_out | output | 64 | Identifier built during the pass |
| next_disc | output | 8 | Discrepancy position to pass to the next call |
| status | output | 2 | 0 ok, 1 no presence, 2 data error |
| done | output | 1 | One-cycle pulse marking the end of a pass |

## Verification
On every cycle, the assertions check the request handshake, which is one cycle long with none outstanding twice. They also check the shape of the `done` pulse and that outputs hold while idle. A further assertion checks that a reset slot comes first. The remaining assertions check that a missing presence or a double-1 read ends the pass at once, with the right code and no further request.

Only the bench scenarios can show the branch choice and the discrepancy bookkeeping, because these depend on the device population on the bus. The bench models a wired-AND bus with devices that drop out of the search. It sweeps a conflict over every bit position with two devices, and enumerates four-device sets to completion. This tests the rule that uses the previous identifier bit, the command byte, the slot count, and the order in which identifier bits are stored.

// File: rtl/owsr_pkg.sv
package owsr_pkg;

   typedef enum logic [1:0] {
      OP_RESET = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2
   } owsr_op_e;

   typedef enum logic [1:0] {
      STAT_OK     = 2'd0,
      STAT_NOPRES = 2'd1,
      STAT_DATA   = 2'd2
   } owsr_stat_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_RESET = 3'd1,
      PH_CMD   = 3'd2,
      PH_RDT   = 3'd3,
      PH_RDC   = 3'd4,
      PH_WR    = 3'd5
   } owsr_phase_e;

endpackage

// File: rtl/owsr_branch.sv
// Combinational branch decision for one identifier position.
module owsr_branch #(
   parameter int POS_W = 8
) (
   input  logic             rd_true,
   input  logic             rd_comp,
   input  logic [POS_W-1:0] disc,
   input  logic [POS_W-1:0] pos,
   input  logic             prev_bit,
   output logic             choose,
   output logic             took_one,
   output logic             err
);
   logic conflict;
   logic pick_one;

   always_comb begin
      conflict = !rd_true && !rd_comp;
      err      = rd_true && rd_comp;
      pick_one = (disc > pos) || (prev_bit && (disc != pos));
      choose   = conflict ? pick_one : rd_true;
      took_one = conflict && pick_one;
   end
endmodule

// File: rtl/owsr_idreg.sv
// Identifier register: loaded with the previous identifier, rewritten bit by bit.
module owsr_idreg #(
   parameter int ID_W      = 64,
   parameter int POS_W     = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ID_W-1:0]  load_val,
   input  logic             we,
   input  logic [POS_W-1:0] pos,
   input  logic             wbit,
   output logic [ID_W-1:0]  id,
   output logic             prev_bit
);
   localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;

   logic [POS_W-1:0] idx_full;
   logic [IDX_W-1:0] idx;
   logic [ID_W-1:0]  id_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign idx_full = POS_W'(ID_W) - pos;
      end else begin : g_msb
         assign idx_full = pos - POS_W'(1);
      end
   endgenerate

   assign idx      = idx_full[IDX_W-1:0];
   assign prev_bit = id_q[idx];
   assign id       = id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q <= '0;
      end else if (load) begin
         id_q <= load_val;
      end else if (we) begin
         id_q[idx] <= wbit;
      end
   end
endmodule

// File: rtl/owsr_ctrl.sv
// Pass sequencer: reset slot, command bits, then read/read/write per position.
module owsr_ctrl
   import owsr_pkg::*;
#(
   parameter int              ID_W      = 64,
   parameter int              POS_W     = 8,
   parameter int              CMD_W     = 8,
   parameter logic [CMD_W-1:0] CMD_CODE = 8'hF0,
   parameter logic [POS_W-1:0] LAST_MARK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [POS_W-1:0] start_disc,
   input  logic             bus_ack,
   input  logic             bus_rbit,
   input  logic             choose,
   input  logic             took_one,
   input  logic             err,
   output owsr_phase_e      phase,
   output logic             busy,
   output logic             bus_req,
   output owsr_op_e         bus_op,
   output logic             bus_wbit,
   output logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] disc,
   output logic             rd_true,
   output logic             load,
   output logic             id_we,
   output logic             done,
   output owsr_stat_e       status,
   output logic [POS_W-1:0] next_disc
);
   localparam int CB_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;
   localparam logic [CB_W-1:0] CB_LAST = CB_W'(CMD_W - 1);

   owsr_phase_e      ph_q;
   logic             pend_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] disc_q;
   logic [CB_W-1:0]  cb_q;
   logic             rt_q;
   logic             wb_q;
   logic             done_q;
   owsr_stat_e       stat_q;
   logic [POS_W-1:0] nd_q;
   logic             acked;

   assign phase     = ph_q;
   assign busy      = (ph_q != PH_IDLE);
   assign bus_req   = busy && !pend_q;
   assign acked     = bus_ack && pend_q;
   assign pos       = pos_q;
   assign disc      = disc_q;
   assign rd_true   = rt_q;
   assign load      = start && !busy;
   assign id_we     = acked && (ph_q == PH_RDC) && !err;
   assign done      = done_q;
   assign status    = stat_q;
   assign next_disc = nd_q;

   always_comb begin
      case (ph_q)
         PH_RESET:        bus_op = OP_RESET;
         PH_RDT, PH_RDC:  bus_op = OP_READ;
         default:         bus_op = OP_WRITE;
      endcase
      case (ph_q)
         PH_CMD:  bus_wbit = CMD_CODE[cb_q];
         PH_WR:   bus_wbit = wb_q;
         default: bus_wbit = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         pend_q <= 1'b0;
         pos_q  <= '0;
         disc_q <= '0;
         cb_q   <= '0;
         rt_q   <= 1'b0;
         wb_q   <= 1'b0;
         done_q <= 1'b0;
         stat_q <= STAT_OK;
         nd_q   <= LAST_MARK;
      end else begin
         done_q <= 1'b0;
         if (bus_req) pend_q <= 1'b1;
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q   <= PH_RESET;
                  pend_q <= 1'b0;
                  pos_q  <= POS_W'(ID_W);
                  disc_q <= start_disc;
                  cb_q   <= '0;
                  stat_q <= STAT_OK;
                  nd_q   <= LAST_MARK;
               end
            end
            PH_RESET: begin
               if (acked) begin
                  pend_q <= 1'b0;
                  if (!bus_rbit) begin
                     ph_q   <= PH_IDLE;
                     stat_q <= STAT_NOPRES;
                     done_q <= 1'b1;
                  end else begin
                     ph_q <= PH_CMD;
                  end
               end
            end
            PH_CMD: begin
               if (acked) begin
                  pend_q <= 1'b0;
                  if (cb_q == CB_LAST) ph_q <= PH_RDT;
                  else                 cb_q <= cb_q + CB_W'(1);
               end
            end
            PH_RDT: begin
               if (acked) begin
                  pend_q <= 1'b0;
                  rt_q   <= bus_rbit;
                  ph_q   <= PH_RDC;
               end
            end
            PH_RDC: begin
               if (acked) begin
                  pend_q <= 1'b0;
                  if (err) begin
                     ph_q   <= PH_IDLE;
                     stat_q <= STAT_DATA;
                     done_q <= 1'b1;
                  end else begin
                     wb_q <= choose;
                     if (took_one) nd_q <= pos_q;
                     ph_q <= PH_WR;
                  end
               end
            end
            PH_WR: begin
               if (acked) begin
                  pend_q <= 1'b0;
                  if (pos_q == POS_W'(1)) begin
                     ph_q   <= PH_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     pos_q <= pos_q - POS_W'(1);
                     ph_q  <= PH_RDT;
                  end
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/owsr_search_pass.sv
module owsr_search_pass
   import owsr_pkg::*;
#(
   parameter int               ID_W      = 64,
   parameter int               POS_W     = 8,
   parameter int               CMD_W     = 8,
   parameter logic [CMD_W-1:0] CMD_CODE  = 8'hF0,
   parameter logic [POS_W-1:0] LAST_MARK = '0,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [POS_W-1:0] start_disc,
   input  logic [ID_W-1:0]  prev_id,
   output logic             bus_req,
   output logic [1:0]       bus_op,
   output logic             bus_wbit,
   input  logic             bus_ack,
   input  logic             bus_rbit,
   output logic [ID_W-1:0]  id_out,
   output logic [POS_W-1:0] next_disc,
   output logic [1:0]       status,
   output logic             done
);
   generate
      if (ID_W < 2) begin : g_bad_id
         $error("ID_W must be at least 2");
      end
      if (ID_W >= (2 ** POS_W) - 1) begin : g_bad_pos
         $error("POS_W too narrow for ID_W and the fresh-start marker");
      end
      if (CMD_W < 1) begin : g_bad_cmd
         $error("CMD_W must be at least 1");
      end
   endgenerate

   owsr_phase_e      phase_w;
   owsr_op_e         op_w;
   owsr_stat_e       stat_w;
   logic             busy_w;
   logic [POS_W-1:0] pos_w;
   logic [POS_W-1:0] disc_w;
   logic             rt_w;
   logic             load_w;
   logic             we_w;
   logic             choose_w;
   logic             took_w;
   logic             err_w;
   logic             prev_bit_w;

   owsr_ctrl #(
      .ID_W(ID_W), .POS_W(POS_W), .CMD_W(CMD_W),
      .CMD_CODE(CMD_CODE), .LAST_MARK(LAST_MARK)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .start_disc(start_disc),
      .bus_ack(bus_ack), .bus_rbit(bus_rbit),
      .choose(choose_w), .took_one(took_w), .err(err_w),
      .phase(phase_w), .busy(busy_w), .bus_req(bus_req), .bus_op(op_w),
      .bus_wbit(bus_wbit), .pos(pos_w), .disc(disc_w), .rd_true(rt_w),
      .load(load_w), .id_we(we_w), .done(done), .status(stat_w),
      .next_disc(next_disc)
   );

   owsr_branch #(.POS_W(POS_W)) u_branch (
      .rd_true(rt_w), .rd_comp(bus_rbit), .disc(disc_w), .pos(pos_w),
      .prev_bit(prev_bit_w), .choose(choose_w), .took_one(took_w),
      .err(err_w)
   );

   owsr_idreg #(.ID_W(ID_W), .POS_W(POS_W), .LSB_FIRST(LSB_FIRST)) u_id (
      .clk(clk), .rst_n(rst_n), .load(load_w), .load_val(prev_id),
      .we(we_w), .pos(pos_w), .wbit(choose_w), .id(id_out),
      .prev_bit(prev_bit_w)
   );

   assign bus_op = op_w;
   assign status = stat_w;
endmodule

// File: rtl/owsr_pass_chk.sv
module owsr_pass_chk #(
   parameter int ID_W  = 64,
   parameter int POS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             bus_req,
   input logic [1:0]       bus_op,
   input logic             bus_ack,
   input logic             bus_rbit,
   input logic [ID_W-1:0]  id_out,
   input logic [POS_W-1:0] next_disc,
   input logic [1:0]       status,
   input logic             done,
   input logic             busy,
   input logic [2:0]       phase,
   input logic             rd_true
);
   assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> !bus_req);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(id_out) && $stable(next_disc) && $stable(status)));

   assert_first_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (bus_req && bus_op == 2'd0));

   assert_nopres_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && phase == 3'd1 && !bus_rbit) |=> (done && status == 2'd1 && !bus_req));

   assert_data_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ack && phase == 3'd4 && rd_true && bus_rbit) |=> (done && status == 2'd2 && !bus_req));

   assert_quiet_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);

   assert_disc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd0) |-> (next_disc <= POS_W'(ID_W)));
endmodule

bind owsr_search_pass owsr_pass_chk #(.ID_W(ID_W), .POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req),
   .bus_op(bus_op), .bus_ack(bus_ack), .bus_rbit(bus_rbit),
   .id_out(id_out), .next_disc(next_disc), .status(status), .done(done),
   .busy(busy_w), .phase(phase_w), .rd_true(rt_w)
);

// File: tb/tb_owsr_search_pass.sv
`timescale 1ns/1ps
module tb_owsr_search_pass;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  start_disc = 8'hFF;
   logic [63:0] prev_id = '0;
   logic        bus_req;
   logic [1:0]  bus_op;
   logic        bus_wbit;
   logic        bus_ack = 1'b0;
   logic        bus_rbit = 1'b0;
   logic [63:0] id_out;
   logic [7:0]  next_disc;
   logic [1:0]  status;
   logic        done;

   int errors = 0;
   int checks = 0;

   // bus model state
   logic [63:0] dev_id [4];
   logic [3:0]  dev_act;
   int          n_dev = 0;
   bit          jam = 1'b0;
   int          slot_cnt = 0;
   int          cmd_cnt = 0;
   logic [7:0]  cmd_rx = '0;
   int          bpos = 0;
   bit          sub = 1'b0;
   logic [63:0] wr_id = '0;

   always #2 clk = ~clk;

   owsr_search_pass dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_disc(start_disc),
      .prev_id(prev_id), .bus_req(bus_req), .bus_op(bus_op),
      .bus_wbit(bus_wbit), .bus_ack(bus_ack), .bus_rbit(bus_rbit),
      .id_out(id_out), .next_disc(next_disc), .status(status), .done(done)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // slot engine with wired-AND devices
   initial begin
      forever begin
         @(negedge clk);
         bus_ack = 1'b0;
         if (bus_req) begin
            logic [1:0] op;
            logic       wb;
            logic       r;
            op = bus_op;
            wb = bus_wbit;
            @(negedge clk);
            r = 1'b1;
            if (op == 2'd0) begin
               slot_cnt = 1;
               r = (n_dev > 0);
               dev_act = '1;
               cmd_cnt = 0; cmd_rx = '0; bpos = 0; sub = 1'b0; wr_id = '0;
            end else begin
               slot_cnt++;
               if (op == 2'd1) begin
                  if (cmd_cnt < 8) begin
                     cmd_rx[cmd_cnt] = wb;
                     cmd_cnt++;
                  end else begin
                     for (int i = 0; i < n_dev; i++)
                        if (dev_id[i][bpos] != wb) dev_act[i] = 1'b0;
                     if (bpos < 64) wr_id[bpos] = wb;
                     bpos++;
                     sub = 1'b0;
                  end
               end else begin
                  if (!jam) begin
                     for (int i = 0; i < n_dev; i++)
                        if (dev_act[i])
                           r = r & (sub ? ~dev_id[i][bpos] : dev_id[i][bpos]);
                  end
                  sub = ~sub;
               end
            end
            bus_rbit = r;
            bus_ack  = 1'b1;
         end
      end
   end

   task automatic run_pass(input logic [7:0] disc, input logic [63:0] prev,
                           output logic [63:0] rid, output logic [7:0] rnd,
                           output logic [1:0] rst);
      @(negedge clk);
      start_disc = disc;
      prev_id    = prev;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      rid = id_out; rnd = next_disc; rst = status;
      @(negedge clk);
      chk(!done, "R9 done single cycle", 64'(done), 64'd0);
      repeat (3) @(negedge clk);
      chk(id_out == rid && next_disc == rnd && status == rst,
          "R9 outputs held after done", id_out, rid);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] rid;
      logic [7:0]  rnd;
      logic [1:0]  rst;
      logic [63:0] base;
      logic [63:0] b1;
      logic [63:0] b2;
      logic [7:0]  p1;
      logic [7:0]  p2;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: state after reset
      chk(!bus_req && !done, "R1 no request or done", {62'd0, bus_req, done}, 64'd0);
      chk(status == 2'd0 && next_disc == 8'd0, "R1 status and next_disc",
          {48'd0, next_disc, 6'd0, status}, 64'd0);
      chk(id_out == 64'd0, "R1 id cleared", id_out, 64'd0);

      // R2: no presence
      n_dev = 0;
      run_pass(8'hFF, 64'd0, rid, rnd, rst);
      chk(rst == 2'd1, "R2 presence error status", 64'(rst), 64'd1);
      chk(slot_cnt == 1, "R2 single reset slot", 64'(slot_cnt), 64'd1);

      // R5: both reads high at the first position
      n_dev = 1; dev_id[0] = 64'h0123_4567_89AB_CDEF; jam = 1'b1;
      run_pass(8'hFF, 64'd0, rid, rnd, rst);
      chk(rst == 2'd2, "R5 data error status", 64'(rst), 64'd2);
      chk(slot_cnt == 11, "R5 stops after complement read", 64'(slot_cnt), 64'd11);
      jam = 1'b0;

      // single device: no conflicts
      run_pass(8'hFF, 64'd0, rid, rnd, rst);
      chk(cmd_rx == 8'hF0, "R3 command byte", 64'(cmd_rx), 64'hF0);
      chk(slot_cnt == 201, "R4 slot count", 64'(slot_cnt), 64'd201);
      chk(rid == dev_id[0] && rst == 2'd0, "R8 single device id", rid, dev_id[0]);
      chk(rnd == 8'd0, "R7 no conflict marker", 64'(rnd), 64'd0);

      // two devices: conflict swept over every bit position
      for (int k = 0; k < 64; k++) begin
         b1   = 64'd1 << k;
         base = 64'hA5C3_0F96_7E18_D24B & ~b1;
         p1   = 8'(64 - k);
         n_dev = 2; dev_id[0] = base; dev_id[1] = base | b1;
         run_pass(8'hFF, 64'd0, rid, rnd, rst);
         chk(rid == (base | b1), "R6 fresh pass takes 1 at conflict", rid, base | b1);
         chk(rnd == p1, "R7 next_disc at conflict", 64'(rnd), 64'(p1));
         chk(wr_id == rid, "R8 stored bits equal written bits", rid, wr_id);
         run_pass(rnd, rid, rid, rnd, rst);
         chk(rid == base, "R6 equal position takes 0", rid, base);
         chk(rnd == 8'd0 && rst == 2'd0, "R7 last device marker", 64'(rnd), 64'd0);
      end

      // four devices: two conflict positions, full enumeration
      for (int t = 0; t < 4; t++) begin
         int k1;
         int k2;
         k1 = t * 13;
         k2 = k1 + 5 + t * 3;
         b1 = 64'd1 << k1;
         b2 = 64'd1 << k2;
         p1 = 8'(64 - k1);
         p2 = 8'(64 - k2);
         base = 64'h3C5A_9966_F00F_1248 & ~(b1 | b2);
         n_dev = 4;
         dev_id[0] = base; dev_id[1] = base | b1;
         dev_id[2] = base | b2; dev_id[3] = base | b1 | b2;
         run_pass(8'hFF, 64'd0, rid, rnd, rst);
         chk(rid == (base | b1 | b2) && rnd == p2, "R6 quad pass 1",
             rid, base | b1 | b2);
         run_pass(rnd, rid, rid, rnd, rst);
         chk(rid == (base | b1) && rnd == p1, "R6 quad pass 2 follows previous 1",
             rid, base | b1);
         run_pass(rnd, rid, rid, rnd, rst);
         chk(rid == (base | b2) && rnd == p2, "R7 quad pass 3", rid, base | b2);
         run_pass(rnd, rid, rid, rnd, rst);
         chk(rid == base && rnd == 8'd0 && rst == 2'd0, "R7 quad pass 4 ends",
             rid, base);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule